// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block arbitrates among seven interrupt sources for a small processor core. Each source can be enabled on its own, and a master enable bit gates all of them. A one-bit priority per source places it in the high or the low level. Once per machine cycle, marked by `sample_en`, the arbiter looks at the enabled requests and picks a winner. The high level always beats the low level, and inside a level a fixed polling order settles ties. The winner is presented as a registered request strobe and a 16-bit vector address. Both are held until the core acknowledges.

The arbiter keeps one in-service flag per level, so handlers can nest. A running low-level handler can be preempted by a high-level request, but not by another low-level one. Nothing can preempt a running high-level handler. An acknowledge marks the granted level as in service. A return pulse retires the highest level that is active. Clearing the request flags is left to the surrounding logic.

Top module: `irq_arbiter`

## Requirements
- R1: The vector issued for each source is: external line A 0003h, timer A 000Bh, external line B 0013h, timer B 001Bh, UART 0023h, timer C 002Bh, synchronous serial channel 0043h.
- R2: `en_reg` bits 6..0 enable the sources external A (bit 0), timer A (1), external B (2), timer B (3), UART (4), timer C (5) and serial channel (6). A source whose bit is 0 never wins arbitration.
- R3: While `en_reg[7]` (master enable) is 0, no request is raised, whatever the flags are.
- R4: `pri_reg` bits 6..0 use the same source positions, with 1 meaning high level. When enabled requests of both levels are pending, a high-level source wins.
- R5: Within one level, the first source in this order wins: external A, serial channel, timer A, external B, timer B, UART, timer C.
- R6: `flag_in` bits are: 0 external A, 1 timer A, 2 external B, 3 timer B, 4 UART receive, 5 UART transmit, 6 timer C overflow, 7 timer C external, 8 serial channel. The UART source is bit 4 OR bit 5. The timer C source is bit 6 OR bit 7.
- R7: While only a low-level handler is in service, a low-level request raises nothing, and a high-level request is granted.
- R8: While a high-level handler is in service, no request is raised.
- R9: `ack` while `irq_req` is 1 drops `irq_req` on the next edge and marks the granted level as in service.
- R10: A `reti` pulse clears the high-level in-service flag if it is set, and otherwise the low-level flag.
- R11: Arbitration happens only on edges where `sample_en` is 1. After `irq_req` rises, it and `irq_vec` stay unchanged until `ack`, even if the flags change.
- R12: After reset, `irq_req` is 0, `irq_vec` is 0000h, and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Machine-cycle strobe; requests are arbitrated on these edges |
| flag_in | input | 9 | Raw request flags (positions per R6) |
| en_reg | input | 8 | Per-source enables, bit 7 master enable |
| pri_reg | input | 8 | Per-source level, bit 7 unused |
| ack | input | 1 | Core accepts the presented vector |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Vector address of the granted source |

## Verification
Several behaviours are checked by assertions on every cycle. These are: the held request and vector staying stable until acknowledge; no grant while the high level is in service, while the master enable is off, or while a low handler runs with no high request pending; acknowledge setting the matching in-service flag; and a return retiring the high flag before the low one. Other behaviours can only be shown by the bench's scenarios, because they depend on which source is expected to win. These are the vector address of each source, the polling order inside a level, the OR-merging of the UART and timer C flags, per-source masking, and the nesting sequence of low grant, high preemption, blocked requests and staged returns.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NSRC   = 7;
  localparam int FLAG_W = 9;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int VEC_W  = 16;
  localparam int SSC_IDX = NSRC - 1;

  // vector address for a source index (enable-register position)
  function automatic logic [VEC_W-1:0] vec_of(input int unsigned idx);
    if (idx == SSC_IDX) return VEC_W'(16'h0043);
    return VEC_W'(3 + 8 * idx);
  endfunction

  // source index polled at rank k (rank 0 first)
  function automatic int unsigned poll_src(input int unsigned k);
    if (k == 0) return 0;
    if (k == 1) return SSC_IDX;
    return k - 1;
  endfunction
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
  import irq_arb_pkg::*;
(
  input  logic [FLAG_W-1:0] flag_in,
  output logic [NSRC-1:0]   src
);
  always_comb begin
    src[0] = flag_in[0];
    src[1] = flag_in[1];
    src[2] = flag_in[2];
    src[3] = flag_in[3];
    src[4] = flag_in[4] | flag_in[5];
    src[5] = flag_in[6] | flag_in[7];
    src[6] = flag_in[8];
  end
endmodule

// File: rtl/irq_poll_pick.sv
module irq_poll_pick
  import irq_arb_pkg::*;
(
  input  logic [NSRC-1:0]  mask,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (mask[poll_src(k)]) begin
        any = 1'b1;
        idx = IDX_W'(poll_src(k));
      end
    end
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic grant_hi,
  input  logic reti,
  output logic isr_hi,
  output logic isr_lo
);
  logic hi_nx, lo_nx;

  always_comb begin
    hi_nx = isr_hi;
    lo_nx = isr_lo;
    if (reti) begin
      if (isr_hi) hi_nx = 1'b0;
      else        lo_nx = 1'b0;
    end
    if (grant) begin
      if (grant_hi) hi_nx = 1'b1;
      else          lo_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_hi <= 1'b0;
      isr_lo <= 1'b0;
    end else begin
      isr_hi <= hi_nx;
      isr_lo <= lo_nx;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic [FLAG_W-1:0] flag_in,
  input  logic [7:0]        en_reg,
  input  logic [7:0]        pri_reg,
  input  logic              ack,
  input  logic              reti,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  logic [NSRC-1:0]  src, pending;
  logic [NSRC-1:0]  lvl_mask [2];
  logic             lvl_any  [2];
  logic [IDX_W-1:0] lvl_idx  [2];
  logic             hi_any, lo_any, take_hi, take_lo, win_valid, grant;
  logic [IDX_W-1:0] win_idx;
  logic             isr_hi, isr_lo, lvl_q;

  irq_src_map u_map (.flag_in(flag_in), .src(src));

  assign pending     = src & en_reg[NSRC-1:0] & {NSRC{en_reg[7]}};
  assign lvl_mask[1] = pending & pri_reg[NSRC-1:0];
  assign lvl_mask[0] = pending & ~pri_reg[NSRC-1:0];

  for (genvar lv = 0; lv < 2; lv++) begin : g_lvl
    irq_poll_pick u_pick (.mask(lvl_mask[lv]), .any(lvl_any[lv]), .idx(lvl_idx[lv]));
  end

  assign hi_any    = lvl_any[1];
  assign lo_any    = lvl_any[0];
  assign take_hi   = hi_any && !isr_hi;
  assign take_lo   = !hi_any && lo_any && !isr_hi && !isr_lo;
  assign win_valid = take_hi || take_lo;
  assign win_idx   = take_hi ? lvl_idx[1] : lvl_idx[0];
  assign grant     = ack && irq_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      lvl_q   <= 1'b0;
    end else if (grant) begin
      irq_req <= 1'b0;
    end else if (sample_en && !irq_req && win_valid) begin
      irq_req <= 1'b1;
      irq_vec <= vec_of(win_idx);
      lvl_q   <= take_hi;
    end
  end

  irq_svc_track u_svc (
    .clk(clk), .rst_n(rst_n), .grant(grant), .grant_hi(lvl_q),
    .reti(reti), .isr_hi(isr_hi), .isr_lo(isr_lo)
  );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sample_en,
  input logic        gen,
  input logic        ack,
  input logic        reti,
  input logic        irq_req,
  input logic [15:0] irq_vec,
  input logic        lvl_q,
  input logic        hi_any,
  input logic        isr_hi,
  input logic        isr_lo
);
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !ack) |=> (irq_req && $stable(irq_vec))); // R11
  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !irq_req && !gen) |=> !irq_req); // R3
  AST_HI_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !irq_req && isr_hi) |=> !irq_req); // R8
  AST_LO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !irq_req && isr_lo && !hi_any) |=> !irq_req); // R7
  AST_ACK_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && lvl_q) |=> (isr_hi && !irq_req)); // R9
  AST_ACK_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !lvl_q) |=> (isr_lo && !irq_req)); // R9
  AST_RET_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && isr_hi && !(ack && irq_req)) |=> (!isr_hi && isr_lo == $past(isr_lo))); // R10
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .gen(en_reg[7]),
  .ack(ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec),
  .lvl_q(lvl_q), .hi_any(hi_any), .isr_hi(isr_hi), .isr_lo(isr_lo)
);

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_en = 1'b0;
  logic [8:0]  flag_in = '0;
  logic [7:0]  en_reg = '0;
  logic [7:0]  pri_reg = '0;
  logic        ack = 1'b0;
  logic        reti = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_arbiter u_dut (.*);

  function automatic logic [15:0] exp_vec(input int s);
    case (s)
      0: return 16'h0003;  1: return 16'h000B;  2: return 16'h0013;
      3: return 16'h001B;  4: return 16'h0023;  5: return 16'h002B;
      default: return 16'h0043;
    endcase
  endfunction

  function automatic int flag_bit(input int s);
    case (s)
      4: return 4;  5: return 6;  6: return 8;
      default: return s;
    endcase
  endfunction

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_vec(input string tag, input logic [15:0] v);
    check(tag, {irq_req, irq_vec}, {1'b1, v});
  endtask

  task automatic chk_none(input string tag);
    check(tag, 17'(irq_req), 17'd0);
  endtask

  task automatic pulse_sample();
    sample_en = 1'b1; @(negedge clk); sample_en = 1'b0;
  endtask
  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask
  task automatic pulse_reti();
    reti = 1'b1; @(negedge clk); reti = 1'b0;
  endtask
  task automatic cleanup();
    flag_in = '0; pulse_reti(); pulse_reti();
  endtask

  task automatic t_reset();
    check("R12 reset", {irq_req, irq_vec}, 17'd0);
  endtask

  task automatic t_each_source();
    en_reg = 8'hFF; pri_reg = 8'h00;
    for (int s = 0; s < 7; s++) begin
      flag_in = '0; flag_in[flag_bit(s)] = 1'b1;
      pulse_sample();
      chk_vec($sformatf("R1 source %0d", s), exp_vec(s));
      pulse_ack();
      chk_none("R9 ack drops request");
      cleanup();
    end
    flag_in = 9'h020; pulse_sample(); chk_vec("R6 uart tx", 16'h0023); pulse_ack(); cleanup();
    flag_in = 9'h080; pulse_sample(); chk_vec("R6 timer C ext", 16'h002B); pulse_ack(); cleanup();
  endtask

  task automatic t_enables();
    flag_in = 9'h1FF; en_reg = 8'h7F; pri_reg = 8'h00;
    pulse_sample(); chk_none("R3 master off");
    en_reg = 8'h84; pulse_sample(); chk_vec("R2 only ext B enabled", 16'h0013);
    pulse_ack(); cleanup();
  endtask

  task automatic t_poll();
    en_reg = 8'hFF; pri_reg = 8'h00;
    flag_in = 9'h1FF; pulse_sample(); chk_vec("R5 first ext A", 16'h0003); pulse_ack(); cleanup();
    flag_in = 9'h1FE; pulse_sample(); chk_vec("R5 then serial", 16'h0043); pulse_ack(); cleanup();
    flag_in = 9'h0FE; pulse_sample(); chk_vec("R5 then timer A", 16'h000B); pulse_ack(); cleanup();
    flag_in = 9'h0F8; pulse_sample(); chk_vec("R5 then timer B", 16'h001B); pulse_ack(); cleanup();
    pri_reg = 8'h7F;
    flag_in = 9'h0F0; pulse_sample(); chk_vec("R5 high level uart", 16'h0023); pulse_ack(); cleanup();
    pri_reg = 8'h00;
  endtask

  task automatic t_levels();
    en_reg = 8'hFF; pri_reg = 8'h20;
    flag_in = 9'h1FF; pulse_sample(); chk_vec("R4 high timer C wins", 16'h002B);
    pulse_ack(); cleanup(); pri_reg = 8'h00;
  endtask

  task automatic t_nesting();
    en_reg = 8'hFF; pri_reg = 8'h48; // timer B and serial high
    flag_in = 9'h004; pulse_sample(); chk_vec("R7 low grant", 16'h0013); pulse_ack();
    flag_in = 9'h001; pulse_sample(); chk_none("R7 low blocked by low");
    flag_in = 9'h008; pulse_sample(); chk_vec("R7 high preempts low", 16'h001B); pulse_ack();
    flag_in = 9'h100; pulse_sample(); chk_none("R8 high not preempted");
    flag_in = 9'h001; pulse_sample(); chk_none("R8 low blocked");
    pulse_reti();
    flag_in = 9'h001; pulse_sample(); chk_none("R10 low still in service");
    flag_in = 9'h100; pulse_sample(); chk_vec("R10 high cleared first", 16'h0043); pulse_ack();
    flag_in = '0; pulse_reti(); pulse_reti();
    flag_in = 9'h001; pulse_sample(); chk_vec("R10 both cleared", 16'h0003); pulse_ack();
    cleanup(); pri_reg = 8'h00;
  endtask

  task automatic t_hold();
    en_reg = 8'hFF; pri_reg = 8'h00;
    flag_in = 9'h001;
    repeat (3) @(negedge clk);
    chk_none("R11 no sample no request");
    flag_in = 9'h004; pulse_sample(); chk_vec("R11 grant ext B", 16'h0013);
    flag_in = 9'h001; pri_reg = 8'h01; pulse_sample();
    repeat (2) @(negedge clk);
    chk_vec("R11 vector held until ack", 16'h0013);
    pulse_ack(); cleanup(); pri_reg = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_each_source();
    t_enables();
    t_poll();
    t_levels();
    t_nesting();
    t_hold();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule